// File: doc/BRIEF.md
# Front-Panel Operation Sequencer

This block sits behind the operator switches of a small computer. It turns a one-cycle request pulse into a short, timed burst of control strobes that drive the memory and the program-counter path. Five operations can be requested: load address, examine, examine next, deposit and deposit next. When the block is idle and a request arrives, it stores the chosen operation and starts a private phase generator. The generator steps through the ordered phases A, B, C and D, and each phase lasts `PHASE_CYCLES` clock cycles.

Operations with no auto-advance stop the generator after phase B. The two "next" operations run all four phases. In phases C and D they copy the incremented address into the program counter. Every strobe is the OR of the contributions of the active operation, taken from the current phase. When the final phase ends, the stored operation returns to idle and the busy flag drops. Requests that arrive while the block is busy are dropped.

Top module: `fp_op_sequencer`

## Requirements
- R1: After reset, busy and all six strobes are low.
- R2: When the block is idle, a request pulse sampled at a clock edge is accepted. Busy is high from the next cycle until the final phase ends.
- R3: When several requests arrive in the same cycle, only one is taken, in this order: load address, deposit next, deposit, examine next, examine.
- R4: Load address, examine and deposit run phases A and B only, so busy lasts 2·PHASE_CYCLES cycles. Examine next and deposit next run A through D, so busy lasts 4·PHASE_CYCLES cycles.
- R5: Load address drives the address-switch select in phases A and B, and drives program-counter load in phase B only. It drives no other strobe.
- R6: Both examine operations drive memory read in phase A and incrementer load in phase B.
- R7: Both deposit operations drive incrementer load in phase A and memory write in phase B.
- R8: Examine next and deposit next drive incrementer select and program-counter load together in phases C and D.
- R9: A request that arrives while busy is high is ignored. It changes neither the strobe pattern nor the length of the running sequence, and it starts no new sequence afterwards.
- R10: Memory read and memory write are never high together, and no strobe is high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_load_addr | input | 1 | Load-address request pulse |
| req_examine | input | 1 | Examine request pulse |
| req_examine_next | input | 1 | Examine-next request pulse |
| req_deposit | input | 1 | Deposit request pulse |
| req_deposit_next | input | 1 | Deposit-next request pulse |
| busy | output | 1 | A sequence is running |
| sel_switches | output | 1 | Route the address switches onto the address path |
| pc_load | output | 1 | Load the program counter |
| inc_select | output | 1 | Route the incrementer output to the program counter |
| inc_load | output | 1 | Load the incrementer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |

## Verification
A request sampled at clock edge k takes effect in the cycle that follows. Busy and the phase-A strobes are due in cycle k+1. Phase n holds for cycles k+1+n·PHASE_CYCLES through k+(n+1)·PHASE_CYCLES, and the block is idle again in cycle k+1+L, where L is the sequence length. The bench drives every request at a falling edge. It then checks busy and all six strobes at each following falling edge, with the phase index taken from the offset since acceptance. This gives a fixed sampling point one half-cycle after each register update. Stray requests are injected on the same falling edges during busy, so their effect on the cycle after them is checked by the same schedule.

// File: rtl/fp_seq_pkg.sv
// Package: shared types and decode helpers for the front-panel sequencer.
// Assumes four ordered phases and one active operation at a time.
package fp_seq_pkg;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_LOAD    = 3'd1,
        OP_EXAM    = 3'd2,
        OP_EXAM_NX = 3'd3,
        OP_DEP     = 3'd4,
        OP_DEP_NX  = 3'd5
    } op_e;

    localparam int NUM_OPS = 6;

    typedef enum logic [1:0] {
        PH_A = 2'd0,
        PH_B = 2'd1,
        PH_C = 2'd2,
        PH_D = 2'd3
    } phase_e;

    typedef struct packed {
        logic sel_switches;
        logic pc_load;
        logic inc_select;
        logic inc_load;
        logic mem_rd;
        logic mem_wr;
    } strobes_t;

    // True for operations that stop after phase B.
    function automatic logic op_is_short(input op_e op);
        return !(op == OP_EXAM_NX || op == OP_DEP_NX);
    endfunction

    // Contribution of one operation to the strobes in a given phase.
    function automatic strobes_t op_contrib(input op_e op, input phase_e ph);
        strobes_t s;
        s = '0;
        unique case (op)
            OP_LOAD: begin
                s.sel_switches = (ph == PH_A) || (ph == PH_B);
                s.pc_load      = (ph == PH_B);
            end
            OP_EXAM, OP_EXAM_NX: begin
                s.mem_rd   = (ph == PH_A);
                s.inc_load = (ph == PH_B);
            end
            OP_DEP, OP_DEP_NX: begin
                s.inc_load = (ph == PH_A);
                s.mem_wr   = (ph == PH_B);
            end
            default: s = '0;
        endcase
        if ((op == OP_EXAM_NX || op == OP_DEP_NX) && (ph == PH_C || ph == PH_D)) begin
            s.inc_select = 1'b1;
            s.pc_load    = 1'b1;
        end
        return s;
    endfunction

endpackage

// File: rtl/fp_req_latch.sv
// Request latch: picks one request by fixed priority while idle and holds it
// until the phase generator reports the final cycle of the sequence.
// Assumes request inputs are single-cycle pulses; requests while busy are dropped.
module fp_req_latch
    import fp_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_load_i,
    input  logic req_exam_i,
    input  logic req_exam_nx_i,
    input  logic req_dep_i,
    input  logic req_dep_nx_i,
    input  logic clear_i,
    output op_e  op_o,
    output logic start_o
);

    op_e op_q;
    op_e pick;

    // Fixed-priority selection among simultaneous requests.
    always_comb begin
        if (req_load_i)         pick = OP_LOAD;
        else if (req_dep_nx_i)  pick = OP_DEP_NX;
        else if (req_dep_i)     pick = OP_DEP;
        else if (req_exam_nx_i) pick = OP_EXAM_NX;
        else if (req_exam_i)    pick = OP_EXAM;
        else                    pick = OP_IDLE;
    end

    assign start_o = (op_q == OP_IDLE) && (pick != OP_IDLE);

    // Hold the accepted operation until the sequence ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_IDLE;
        end else if (start_o) begin
            op_q <= pick;
        end else if (clear_i) begin
            op_q <= OP_IDLE;
        end
    end

    assign op_o = op_q;

endmodule

// File: rtl/fp_phase_gen.sv
// Phase generator: once started, steps through phases A..D, each PHASE_CYCLES
// long, and stops after B when short_i is high. last_o marks the final cycle.
// Assumes start_i is only honoured while inactive.
module fp_phase_gen
    import fp_seq_pkg::*;
#(
    parameter int PHASE_CYCLES = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    input  logic   short_i,
    output logic   active_o,
    output phase_e phase_o,
    output logic   last_o
);

    localparam int CNT_W = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PHASE_CYCLES - 1);

    logic             act_q;
    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic             phase_end;

    assign phase_end = act_q && (cnt_q == CNT_MAX);
    assign last_o    = phase_end && ((short_i && ph_q == PH_B) || ph_q == PH_D);

    // Advance the cycle counter and the phase, stopping on the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            ph_q  <= PH_A;
            cnt_q <= '0;
        end else if (!act_q) begin
            if (start_i) begin
                act_q <= 1'b1;
                ph_q  <= PH_A;
                cnt_q <= '0;
            end
        end else if (phase_end) begin
            cnt_q <= '0;
            if (last_o) begin
                act_q <= 1'b0;
                ph_q  <= PH_A;
            end else begin
                ph_q <= phase_e'(ph_q + 2'd1);
            end
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign active_o = act_q;
    assign phase_o  = ph_q;

endmodule

// File: rtl/fp_strobe_decode.sv
// Strobe decode: ORs the per-operation contributions for the current phase.
// Assumes at most one operation code is held at a time; outputs are zero when inactive.
module fp_strobe_decode
    import fp_seq_pkg::*;
(
    input  op_e      op_i,
    input  phase_e   phase_i,
    input  logic     active_i,
    output strobes_t strobes_o
);

    strobes_t contrib [NUM_OPS];

    // One contribution slot per operation code.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        always_comb begin
            if (active_i && op_i == op_e'(3'(g))) contrib[g] = op_contrib(op_e'(3'(g)), phase_i);
            else                                   contrib[g] = '0;
        end
    end

    // OR together every slot to form the outputs.
    always_comb begin
        strobes_o = '0;
        for (int i = 0; i < NUM_OPS; i++) strobes_o = strobes_o | contrib[i];
    end

endmodule

// File: rtl/fp_op_sequencer.sv
// Top: front-panel operation sequencer. It latches a request, runs the phase
// generator for a short (A,B) or long (A..D) sequence, and decodes the strobes.
// Assumes one-cycle request pulses and a synchronous active-low reset.
module fp_op_sequencer
    import fp_seq_pkg::*;
#(
    parameter int PHASE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_load_addr,
    input  logic req_examine,
    input  logic req_examine_next,
    input  logic req_deposit,
    input  logic req_deposit_next,
    output logic busy,
    output logic sel_switches,
    output logic pc_load,
    output logic inc_select,
    output logic inc_load,
    output logic mem_rd,
    output logic mem_wr
);

    op_e      op;
    logic     start;
    logic     active;
    logic     last;
    phase_e   phase;
    strobes_t stb;

    fp_req_latch u_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_load_i   (req_load_addr),
        .req_exam_i   (req_examine),
        .req_exam_nx_i(req_examine_next),
        .req_dep_i    (req_deposit),
        .req_dep_nx_i (req_deposit_next),
        .clear_i      (last),
        .op_o         (op),
        .start_o      (start)
    );

    fp_phase_gen #(.PHASE_CYCLES(PHASE_CYCLES)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .short_i (op_is_short(op)),
        .active_o(active),
        .phase_o (phase),
        .last_o  (last)
    );

    fp_strobe_decode u_dec (
        .op_i     (op),
        .phase_i  (phase),
        .active_i (active),
        .strobes_o(stb)
    );

    assign busy         = (op != OP_IDLE);
    assign sel_switches = stb.sel_switches;
    assign pc_load      = stb.pc_load;
    assign inc_select   = stb.inc_select;
    assign inc_load     = stb.inc_load;
    assign mem_rd       = stb.mem_rd;
    assign mem_wr       = stb.mem_wr;

endmodule

// File: rtl/fp_op_sequencer_chk.sv
// Checker: port-level properties of the sequencer, bound to every instance.
module fp_op_sequencer_chk (
    input logic clk,
    input logic rst_n,
    input logic req_load_addr,
    input logic req_examine,
    input logic req_examine_next,
    input logic req_deposit,
    input logic req_deposit_next,
    input logic busy,
    input logic sel_switches,
    input logic pc_load,
    input logic inc_select,
    input logic inc_load,
    input logic mem_rd,
    input logic mem_wr
);

    logic any_req;
    logic any_stb;
    assign any_req = req_load_addr | req_examine | req_examine_next | req_deposit | req_deposit_next;
    assign any_stb = sel_switches | pc_load | inc_select | inc_load | mem_rd | mem_wr;

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && any_req) |=> busy);

    assert_rdwr_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_strobe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> busy);

    assert_next_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inc_select |-> pc_load);

    assert_switch_alone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_switches |-> !(inc_select || inc_load || mem_rd || mem_wr));

endmodule

bind fp_op_sequencer fp_op_sequencer_chk u_chk (.*);

// File: tb/tb_fp_op_sequencer.sv
module tb_fp_op_sequencer;

    localparam int PH = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] req = '0; // [4]=load [3]=dep_nx [2]=dep [1]=exam_nx [0]=exam
    logic busy, sel_switches, pc_load, inc_select, inc_load, mem_rd, mem_wr;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    fp_op_sequencer #(.PHASE_CYCLES(PH)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_load_addr(req[4]), .req_examine(req[0]), .req_examine_next(req[1]),
        .req_deposit(req[2]), .req_deposit_next(req[3]),
        .busy(busy), .sel_switches(sel_switches), .pc_load(pc_load),
        .inc_select(inc_select), .inc_load(inc_load), .mem_rd(mem_rd), .mem_wr(mem_wr)
    );

    wire [5:0] stb = {sel_switches, pc_load, inc_select, inc_load, mem_rd, mem_wr};

    // op codes in the bench: 1 load, 2 exam, 3 exam_nx, 4 dep, 5 dep_nx
    function automatic int pick_op(input logic [4:0] r);
        if (r[4]) return 1;
        if (r[3]) return 5;
        if (r[2]) return 4;
        if (r[1]) return 3;
        if (r[0]) return 2;
        return 0;
    endfunction

    function automatic int seq_len(input int op);
        return (op == 3 || op == 5) ? 4 * PH : 2 * PH;
    endfunction

    // Expected {sel_sw, pc_ld, inc_sel, inc_ld, rd, wr} for op in phase ph.
    function automatic logic [5:0] exp_stb(input int op, input int ph);
        logic [5:0] s = '0;
        if (op == 1) s = (ph == 0) ? 6'b100000 : (ph == 1) ? 6'b110000 : 6'b0;
        if (op == 2 || op == 3) s = (ph == 0) ? 6'b000010 : (ph == 1) ? 6'b000100 : 6'b0;
        if (op == 4 || op == 5) s = (ph == 0) ? 6'b000100 : (ph == 1) ? 6'b000001 : 6'b0;
        if ((op == 3 || op == 5) && ph >= 2) s = 6'b011000;
        return s;
    endfunction

    task automatic check(input string tag, input logic [6:0] act, input logic [6:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual busy/strobes=%b expected=%b", tag, act, expv);
        end
    endtask

    // Run one request; noise requests are injected while busy (R9).
    task automatic run(input logic [4:0] r, input bit noisy, input string tag);
        int op = pick_op(r);
        int len = seq_len(op);
        @(negedge clk);
        req = r;
        @(negedge clk);
        for (int j = 0; j < len; j++) begin
            check({tag, " R2/R4/R5-R8"}, {busy, stb}, {1'b1, exp_stb(op, j / PH)});
            req = noisy ? 5'($urandom_range(0, 31)) : 5'd0;
            if (j == len - 1) req = '0;
            if (j != len - 1) @(negedge clk);
        end
        @(negedge clk);
        check({tag, " R4/R9 end idle"}, {busy, stb}, 7'b0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R1 reset", {busy, stb}, 7'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {busy, stb}, 7'b0);
        run(5'b10000, 0, "R5 load");
        run(5'b00001, 0, "R6 examine");
        run(5'b00010, 0, "R6 R8 examine next");
        run(5'b00100, 0, "R7 deposit");
        run(5'b01000, 0, "R7 R8 deposit next");
        run(5'b11111, 0, "R3 all");
        run(5'b00101, 0, "R3 dep over exam");
        run(5'b00011, 0, "R3 exnx over exam");
        run(5'b01100, 0, "R3 depnx over dep");
        run(5'b00010, 1, "R9 noisy");
        for (int i = 0; i < 80; i++) begin
            logic [4:0] r = 5'($urandom_range(1, 31));
            if ($urandom_range(0, 1) == 1) r = 5'(1 << $urandom_range(0, 4));
            run(r, 1'($urandom_range(0, 1)), "random R3 R9");
            repeat ($urandom_range(0, 2)) begin
                @(negedge clk);
                check("R10 idle gap", {busy, stb}, 7'b0);
            end
        end
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule